// File: doc/BRIEF.md
# Serial Bus Target Protocol Engine

This block is the bus-facing half of an 8-bit port expander. It runs on a fast system clock and oversamples the two-wire serial bus lines SCL and SDA. Each line is passed through a two-flop synchroniser and then a run-length filter, so pulses shorter than the filter window never reach the protocol logic. From the cleaned lines it detects START, repeated START and STOP. It shifts in the address byte, compares it with a 7-bit target address, acknowledges a match and then moves bytes between the bus and a register back end.

The address is the fixed prefix `0011` in bits 6..3, with three strap inputs in bits 2..0, so the address range is 0x18 to 0x1F. The eighth bit of the address byte selects the direction: 1 is a read and 0 is a write.

In a write, every received byte is acknowledged and handed to the back end with a one-cycle strobe. The first byte after the address carries a flag so that the back end can treat it as a register pointer. In a read, the engine requests a byte from the back end and shifts it out MSB first. It keeps doing so for as long as the controller acknowledges. The back end holds the current pointer, so a read may start straight after the address with no pointer byte. SDA is driven only through an open-drain enable (1 pulls the line low).

Top module: `i2c_target_engine`

## Requirements
- R1: The engine acknowledges an address byte whose upper seven bits equal {4'b0011, strap}. It holds `sda_oe` high for the whole high phase of the ninth clock.
- R2: After an address byte that does not match, `sda_oe` stays low and no write strobe, read request or stop strobe is produced. This lasts until the next START or STOP.
- R3: In a write transfer, each data byte is received MSB first and acknowledged on its ninth clock. It is presented on `wr_data` with a one-cycle `wr_stb`. `wr_first` is 1 for the first byte after the address and 0 for later bytes.
- R4: In a read transfer, the engine pulses `rd_req` after the address ACK and after every controller ACK. It captures `rd_data` in the cycle that `rd_req` is high and drives that byte MSB first.
- R5: A controller NACK after a read byte ends the read. SDA is released and stays released, and no further `rd_req` occurs until a new START.
- R6: A repeated START restarts address decoding without passing through idle. `addr_rw` takes the direction bit of the newest matching address byte.
- R7: A STOP that ends a transfer addressed to this target gives exactly one cycle of `stop_strb`. `wr_stb`, `rd_req` and `stop_strb` are never high in the same cycle.
- R8: While `rst` is high, the engine returns to idle with `sda_oe` low and all strobes low. A STOP that follows a reset produces no `stop_strb`.
- R9: A pulse on SCL or SDA that is shorter than `FILT_LEN` system clocks is ignored. It creates no START, no STOP and no extra data bit.
- R10: `sda_oe` changes only while the filtered SCL is low. This is at least one system clock after the filtered falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Low three address bits |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_rw | output | 1 | Direction bit of the last matching address (1 = read) |
| wr_stb | output | 1 | One-cycle strobe: `wr_data` holds a received byte |
| wr_data | output | 8 | Received write byte |
| wr_first | output | 1 | Byte under `wr_stb` is the first after the address |
| rd_req | output | 1 | One-cycle request; `rd_data` is captured in this cycle |
| rd_data | input | 8 | Byte to transmit, supplied by the back end |
| stop_strb | output | 1 | One-cycle strobe on STOP after a selected transfer |

## Verification
The hardest case to reach is a reset that arrives in the middle of a frame, while the target is pulling SDA low for an address ACK. The bench drives the address bits by hand and raises SCL for the ninth clock. It confirms that the ACK is being driven, then pulses reset while SCL is still high. Afterwards it closes the bus with a STOP and checks that no stop strobe follows. Sub-window pulses are injected on SDA while the bus is idle, and on SCL during the low phase of a data bit. A correctly received byte then shows that no stray edge got through.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // bus free or not yet addressed
    ST_ADDR,   // shifting in the address byte
    ST_AACK,   // driving ACK for the address
    ST_WDATA,  // shifting in a write byte
    ST_WACK,   // driving ACK for a write byte
    ST_RLOAD,  // capturing the byte to transmit
    ST_RDATA,  // shifting out a read byte
    ST_RACK,   // sampling the controller ACK/NACK
    ST_HOLD,   // read ended by NACK, line released
    ST_SKIP    // address mismatch, bus ignored
  } eng_state_t;

endpackage

// File: rtl/i2ct_filter.sv
module i2ct_filter #(
  parameter int   FILT_LEN = 8,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync;
  logic [CW-1:0] run;

  // The output follows the synchronised input only after FILT_LEN
  // consecutive samples that differ from the current output.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= {2{RST_VAL}};
      run  <= '0;
      dout <= RST_VAL;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        run <= '0;
      end else if (run == RUN_LAST) begin
        dout <= sync[1];
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  // SDA edges while SCL stays high are bus conditions, never data
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter int                    DW        = 8,
  parameter int                    ADDR_HI_W = 4,
  parameter int                    STRAP_W   = 3,
  parameter logic [ADDR_HI_W-1:0]  ADDR_HI   = 4'b0011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic               sda_oe,
  output logic               addr_rw,
  output logic               wr_stb,
  output logic [DW-1:0]      wr_data,
  output logic               wr_first,
  output logic               rd_req,
  output logic               stop_strb,
  output eng_state_t         state
);
  localparam int AW = ADDR_HI_W + STRAP_W;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);

  logic [DW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          first;
  logic          mack;

  always_ff @(posedge clk) begin
    wr_stb    <= 1'b0;
    rd_req    <= 1'b0;
    stop_strb <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
      addr_rw  <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      first    <= 1'b0;
      mack     <= 1'b0;
      wr_data  <= '0;
      wr_first <= 1'b0;
    end else if (bus_start) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
      first  <= 1'b1;
    end else if (bus_stop) begin
      if (state != ST_IDLE && state != ST_SKIP) stop_strb <= 1'b1;
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            if (shreg[DW-1 -: AW] == {ADDR_HI, strap}) begin
              state   <= ST_AACK;
              sda_oe  <= 1'b1;
              addr_rw <= shreg[0];
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            if (addr_rw) begin
              rd_req <= 1'b1;
              state  <= ST_RLOAD;
            end else begin
              state <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_FULL) begin
            wr_stb   <= 1'b1;
            wr_data  <= shreg;
            wr_first <= first;
            first    <= 1'b0;
            sda_oe   <= 1'b1;
            state    <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RLOAD: begin
          shreg  <= rd_data;
          sda_oe <= ~rd_data[DW-1];
          cnt    <= '0;
          state  <= ST_RDATA;
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CNT_FULL) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              shreg  <= {shreg[DW-2:0], 1'b0};
              sda_oe <= ~shreg[DW-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              rd_req <= 1'b1;
              state  <= ST_RLOAD;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import i2ct_pkg::*;
#(
  parameter int                    FILT_LEN  = 8,
  parameter int                    DW        = 8,
  parameter int                    ADDR_HI_W = 4,
  parameter int                    STRAP_W   = 3,
  parameter logic [ADDR_HI_W-1:0]  ADDR_HI   = 4'b0011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_oe,
  output logic               addr_rw,
  output logic               wr_stb,
  output logic [DW-1:0]      wr_data,
  output logic               wr_first,
  output logic               rd_req,
  input  logic [DW-1:0]      rd_data,
  output logic               stop_strb
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, bus_start, bus_stop;
  eng_state_t eng_state;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2ct_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_lines[g]),
      .dout (filt_lines[g])
    );
  end

  assign sda_f = filt_lines[0];
  assign scl_f = filt_lines[1];

  i2ct_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2ct_fsm #(
    .DW(DW), .ADDR_HI_W(ADDR_HI_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_s     (sda_f),
    .strap     (strap),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .addr_rw   (addr_rw),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .wr_first  (wr_first),
    .rd_req    (rd_req),
    .stop_strb (stop_strb),
    .state     (eng_state)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       addr_rw,
  input logic       wr_stb,
  input logic       rd_req,
  input logic       stop_strb,
  input eng_state_t state
);
  assert_addr_ack_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK && scl_f) |-> sda_oe);

  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> (!sda_oe && !wr_stb && !rd_req));

  assert_data_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WACK && scl_f) |-> sda_oe);

  assert_rdreq_dir_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> addr_rw);

  assert_nack_release_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> (!sda_oe && !rd_req));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_req, stop_strb}));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!sda_oe && !wr_stb && !rd_req && !stop_strb));

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (!scl_f && !$past(scl_f)));
endmodule

bind i2c_target_engine i2ct_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_f     (scl_f),
  .sda_oe    (sda_oe),
  .addr_rw   (addr_rw),
  .wr_stb    (wr_stb),
  .rd_req    (rd_req),
  .stop_strb (stop_strb),
  .state     (eng_state)
);

// File: tb/test_i2c_target_engine.sv
`timescale 1ns/1ps
module test_i2c_target_engine;
  localparam int Q = 40;        // quarter bit period in system clocks
  localparam int FILT = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_oe, addr_rw, wr_stb, wr_first, rd_req, stop_strb;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sda_bus;

  int n_chk = 0, n_fail = 0;
  int wr_n = 0, rd_n = 0, stop_n = 0, oe_hi_n = 0, oe_viol = 0;
  logic [7:0] rd_cnt = 8'd0;
  logic [7:0] wr_log_d [16];
  logic       wr_log_f [16];
  logic prev_rd = 1'b0, prev_oe = 1'b0, prev_rst = 1'b1;
  bit   done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = 8'hC4 + rd_cnt;

  i2c_target_engine #(.FILT_LEN(FILT)) i_i2c_target_engine (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap(strap),
    .sda_oe(sda_oe), .addr_rw(addr_rw), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_first(wr_first), .rd_req(rd_req), .rd_data(rd_data), .stop_strb(stop_strb)
  );

  // Back-end model and bus observers, sampled away from the active edge
  always @(negedge clk) begin
    if (wr_stb === 1'b1) begin
      wr_log_d[wr_n % 16] = wr_data;
      wr_log_f[wr_n % 16] = wr_first;
      wr_n++;
    end
    if (rd_req === 1'b1) rd_n++;
    if (prev_rd && rd_req === 1'b0) rd_cnt = rd_cnt + 8'd1;
    prev_rd = (rd_req === 1'b1);
    if (stop_strb === 1'b1) stop_n++;
    if (sda_oe === 1'b1) oe_hi_n++;
    if (!rst && !prev_rst && sda_oe !== prev_oe && scl_m) oe_viol++;
    prev_oe  = (sda_oe === 1'b1);
    prev_rst = rst;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic wbit(input logic b, input bit glitch);
    sda_m = b;
    if (glitch) begin
      w(10); scl_m = 1'b1; w(3); scl_m = 1'b0; w(Q - 13);
    end else begin
      w(Q);
    end
    scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(v[i], glitch && i == 4);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = !sda_bus;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1'b1; w(Q); v[i] = sda_bus; w(Q); scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1; w(5); rst = 1'b0; w(2);
    chk("R8", "sda_oe after reset", int'(sda_oe), 0);
    chk("R8", "strobes after reset", int'({wr_stb, rd_req, stop_strb}), 0);
    chk("R8", "addr_rw after reset", int'(addr_rw), 0);
  endtask

  task automatic t_write_burst();
    bit a; int w0 = wr_n, s0 = stop_n;
    bus_start();
    wbyte(8'h3A, 0, a); chk("R1", "ack for address 0x1D write", int'(a), 1);
    wbyte(8'h02, 0, a); chk("R3", "ack pointer byte", int'(a), 1);
    wbyte(8'hA5, 0, a); chk("R3", "ack data byte 1", int'(a), 1);
    wbyte(8'h3C, 0, a); chk("R3", "ack data byte 2", int'(a), 1);
    bus_stop();
    chk("R3", "write strobes", wr_n - w0, 3);
    chk("R3", "byte0 data", int'(wr_log_d[w0 % 16]), 8'h02);
    chk("R3", "byte0 first flag", int'(wr_log_f[w0 % 16]), 1);
    chk("R3", "byte1 data", int'(wr_log_d[(w0+1) % 16]), 8'hA5);
    chk("R3", "byte1 first flag", int'(wr_log_f[(w0+1) % 16]), 0);
    chk("R3", "byte2 data", int'(wr_log_d[(w0+2) % 16]), 8'h3C);
    chk("R6", "addr_rw after write address", int'(addr_rw), 0);
    chk("R7", "one stop strobe", stop_n - s0, 1);
  endtask

  task automatic t_other_strap();
    bit a; int w0 = wr_n;
    strap = 3'b000;
    bus_start();
    wbyte(8'h30, 0, a); chk("R1", "ack for address 0x18", int'(a), 1);
    wbyte(8'h81, 0, a); chk("R3", "ack at address 0x18", int'(a), 1);
    bus_stop();
    chk("R3", "data at address 0x18", int'(wr_log_d[w0 % 16]), 8'h81);
    strap = 3'b101;
  endtask

  task automatic t_mismatch();
    bit a; int w0 = wr_n, s0 = stop_n, o0 = oe_hi_n;
    bus_start();
    wbyte(8'h38, 0, a); chk("R2", "no ack for 0x1C", int'(a), 0);
    wbyte(8'h55, 0, a); chk("R2", "no ack for data after mismatch", int'(a), 0);
    bus_stop();
    chk("R2", "no write strobe", wr_n - w0, 0);
    chk("R2", "sda never driven", oe_hi_n - o0, 0);
    chk("R2", "no stop strobe", stop_n - s0, 0);
  endtask

  task automatic t_read_pointer();
    bit a; logic [7:0] v; int r0 = rd_n, s0 = stop_n;
    logic [7:0] exp0 = 8'hC4 + rd_cnt;
    bus_start();
    wbyte(8'h3A, 0, a); chk("R1", "ack address before pointer", int'(a), 1);
    wbyte(8'h01, 0, a); chk("R3", "ack pointer", int'(a), 1);
    bus_start();
    wbyte(8'h3B, 0, a); chk("R6", "ack address after repeated start", int'(a), 1);
    chk("R6", "addr_rw after repeated start", int'(addr_rw), 1);
    rbyte(1, v); chk("R4", "first read byte", int'(v), int'(exp0));
    rbyte(0, v); chk("R4", "second read byte", int'(v), int'(exp0 + 8'd1));
    w(Q);
    chk("R5", "sda released after NACK", int'(sda_oe), 0);
    chk("R5", "read requests", rd_n - r0, 2);
    bus_stop();
    chk("R5", "no request after NACK", rd_n - r0, 2);
    chk("R7", "stop strobe after read", stop_n - s0, 1);
  endtask

  task automatic t_read_direct();
    bit a; logic [7:0] v; int r0 = rd_n;
    logic [7:0] exp0 = 8'hC4 + rd_cnt;
    bus_start();
    wbyte(8'h3B, 0, a); chk("R4", "ack direct read address", int'(a), 1);
    rbyte(0, v); chk("R4", "direct read byte", int'(v), int'(exp0));
    bus_stop();
    chk("R4", "one read request", rd_n - r0, 1);
  endtask

  task automatic t_glitch();
    bit a; int w0 = wr_n, s0 = stop_n;
    sda_m = 1'b0; w(FILT - 4); sda_m = 1'b1; w(Q);
    chk("R9", "sda glitch gives no stop strobe", stop_n - s0, 0);
    bus_start();
    wbyte(8'h3A, 0, a); chk("R9", "ack after sda glitch", int'(a), 1);
    wbyte(8'h07, 1, a); chk("R9", "ack with scl glitch", int'(a), 1);
    bus_stop();
    chk("R9", "byte with scl glitch", int'(wr_log_d[w0 % 16]), 8'h07);
    chk("R9", "strobe count with scl glitch", wr_n - w0, 1);
  endtask

  task automatic t_reset_midframe();
    int s0 = stop_n;
    logic [7:0] adr = 8'h3A;
    bus_start();
    for (int i = 7; i >= 0; i--) wbit(adr[i], 0);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    chk("R1", "ack driven before reset", int'(sda_oe), 1);
    rst = 1'b1; w(2);
    chk("R8", "reset releases sda mid-frame", int'(sda_oe), 0);
    rst = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    bus_stop();
    chk("R8", "no stop strobe after reset", stop_n - s0, 0);
  endtask

  initial begin
    t_reset();
    t_write_burst();
    t_other_strap();
    t_mismatch();
    t_read_pointer();
    t_read_direct();
    t_glitch();
    t_reset_midframe();
    chk("R10", "sda_oe changes with scl high", oe_viol, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule